// File: doc/BRIEF.md
# Multichannel ADC conversion sequencer

This block drives an external simultaneous-sampling 16-bit converter that has six channels. It divides the system clock down to a sample clock and opens each conversion with a one-period active-low start strobe. It then waits for the converter's active-low end-of-conversion line. Once that line is seen, it reads the three used channels one after another over a shared 16-bit bus, using a channel address and an active-low read strobe.

Each word that is read leaves the block with a one-cycle write enable and a 2-bit channel tag, so that downstream logic can steer it into that channel's buffer. The sequence repeats without a break. A new start strobe follows the last read of the previous conversion directly. If end-of-conversion never arrives, a timeout raises an error pulse and the sequence starts over.

Top module: `adc_seq`

## Requirements
- R1: `samp_clk` has a period of `DIV` system clocks. It is high for the first `DIV/2` clocks of each period, and every state change of the sequencer happens at its rising edge.
- R2: While reset is held and right after it, `hold_n` and `rd_n` are high and `wr_en` and `err` are low.
- R3: Each start strobe holds `hold_n` low for exactly one sample period (`DIV` system clocks).
- R4: After the strobe rises, `eoc_n` is sampled at the end of each sample period. The first sample period after the one in which it is seen low is the first read period. With the converter flagging completion 17 sample edges after the strobe rises, the first word is written `19*DIV` clocks after `hold_n` rises.
- R5: Channels are read in ascending order: `ch_addr` is 0, 1, 2 on every conversion. `rd_n` is low for one sample period per channel, and `rd_n` and `hold_n` are never low together.
- R6: At the end of each read period the bus value is captured. `wr_en` pulses for one clock with `wr_data` equal to the bus and `wr_ch` equal to the channel that was read. Successive words are `DIV` clocks apart.
- R7: The next start strobe begins at the edge where the last word is written, so strobe rises are `22*DIV` clocks apart in steady operation.
- R8: If `eoc_n` has not been seen low `TIMEOUT` sample periods after the strobe rises, `err` pulses for one clock, no word is written, and a new strobe begins in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_data | input | 16 | Converter data bus |
| eoc_n | input | 1 | Active-low end of conversion |
| samp_clk | output | 1 | Divided sample clock |
| hold_n | output | 1 | Active-low conversion start strobe |
| ch_addr | output | 3 | Converter channel address |
| rd_n | output | 1 | Active-low read strobe |
| wr_data | output | 16 | Captured word |
| wr_en | output | 1 | One-cycle write enable for the captured word |
| wr_ch | output | 2 | Channel tag of the captured word |
| err | output | 1 | One-cycle timeout pulse |

## Verification
Some properties are checked on every cycle. These are the strobe width of exactly one sample period, that read and start strobes never overlap, single-cycle write pulses with a tag below three, that each write follows a read period, ascending tags within a conversion, and that an error pulse always coincides with a new strobe. Other behaviour can only be shown by the bench's scenarios, using its converter model. This covers the absolute latency from strobe to first word, the captured data matching the bus per channel, the spacing between conversions, the exact timeout distance, and recovery once end-of-conversion returns.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DIV     = 4,
  parameter int NCH     = 3,
  parameter int TIMEOUT = 32,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] adc_data,
  input  logic          eoc_n,
  output logic          samp_clk,
  output logic          hold_n,
  output logic [2:0]    ch_addr,
  output logic          rd_n,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic [1:0]    wr_ch,
  output logic          err
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_WAIT, S_READ} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] wcnt;
  logic [1:0]    idx;
  logic          tick;

  assign tick     = (cnt == CW'(DIV - 1));
  assign samp_clk = (cnt < CW'(DIV / 2));
  assign hold_n   = (st != S_HOLD);
  assign rd_n     = (st != S_READ);
  assign ch_addr  = {1'b0, idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wcnt    <= '0;
      idx     <= '0;
      wr_data <= '0;
      wr_en   <= 1'b0;
      wr_ch   <= '0;
      err     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      err   <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: st <= S_HOLD;
          S_HOLD: begin
            st   <= S_WAIT;
            wcnt <= '0;
          end
          S_WAIT: begin
            if (!eoc_n) begin
              st  <= S_READ;
              idx <= '0;
            end else if (wcnt == TW'(TIMEOUT - 1)) begin
              st  <= S_HOLD;
              err <= 1'b1;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          default: begin
            wr_data <= adc_data;
            wr_ch   <= idx;
            wr_en   <= 1'b1;
            if (idx == 2'(NCH - 1)) st <= S_HOLD;
            else                    idx <= idx + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

module adc_seq_chk #(
  parameter int DIV = 4,
  parameter int NCH = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_n,
  input logic       rd_n,
  input logic       wr_en,
  input logic [1:0] wr_ch,
  input logic       err
);
  int unsigned lowcnt;
  logic [1:0]  last_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt  <= 0;
      last_ch <= 2'(NCH - 1);
    end else begin
      lowcnt <= hold_n ? 0 : lowcnt + 1;
      if (wr_en) last_ch <= wr_ch;
    end
  end

  assert_hold_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_n) |-> (lowcnt == DIV));
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hold_n && !rd_n));
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_tag_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ch < 2'(NCH)));
  assert_wr_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> !$past(rd_n));
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ch != 0) |-> (wr_ch == last_ch + 1'b1));
  assert_err_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!hold_n && !wr_en));
endmodule

bind adc_seq adc_seq_chk #(.DIV(DIV), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .rd_n(rd_n),
  .wr_en(wr_en), .wr_ch(wr_ch), .err(err)
);

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int TIMEOUT = 32;
  localparam int LAT = 17;

  logic        clk = 0, rst_n = 0;
  logic [15:0] adc_data;
  logic        eoc_n;
  logic        samp_clk, hold_n, rd_n, wr_en, err;
  logic [2:0]  ch_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_ch;

  int vectors = 0, fails = 0;
  int ncyc = 0;
  bit done = 0;

  logic       eoc_en = 1;
  logic       ps, ph, act;
  int         mcnt;
  logic [7:0] conv_id;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  adc_seq #(.DIV(DIV), .NCH(3), .TIMEOUT(TIMEOUT), .DW(16)) dut (
    .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .eoc_n(eoc_n),
    .samp_clk(samp_clk), .hold_n(hold_n), .ch_addr(ch_addr), .rd_n(rd_n),
    .wr_data(wr_data), .wr_en(wr_en), .wr_ch(wr_ch), .err(err));

  assign adc_data = rd_n ? 16'hFFFF : {conv_id, 5'b0, ch_addr};

  always @(negedge clk) begin
    if (!rst_n) begin
      eoc_n <= 1; ps <= 0; ph <= 1; act <= 0; mcnt <= 0; conv_id <= 0;
    end else begin
      if (samp_clk && !ps) begin
        if (!eoc_n) eoc_n <= 1;
        if (hold_n && !ph) begin
          act <= 1; mcnt <= 0;
        end else if (act) begin
          if (mcnt == LAT - 1) begin
            act <= 0;
            if (eoc_en) eoc_n <= 0;
          end
          mcnt <= mcnt + 1;
        end
      end
      if (!hold_n && ph) conv_id <= conv_id + 1;
      ps <= samp_clk; ph <= hold_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act_v, input int exp_v);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic wait_hold_rise(output int t);
    while (hold_n) @(negedge clk);
    while (!hold_n) @(negedge clk);
    t = ncyc;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(hold_n && rd_n && !wr_en && !err, "R2", "outputs in reset", {hold_n, rd_n, wr_en, err}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    check(hold_n && rd_n && !wr_en && !err, "R2", "outputs after reset", {hold_n, rd_n, wr_en, err}, 4'b1100);
  endtask

  task automatic test_sampclk();
    int t0, hi;
    while (samp_clk) @(negedge clk);
    while (!samp_clk) @(negedge clk);
    t0 = ncyc; hi = 0;
    while (samp_clk) begin hi++; @(negedge clk); end
    while (!samp_clk) @(negedge clk);
    check(ncyc - t0 == DIV, "R1", "sample period", ncyc - t0, DIV);
    check(hi == DIV/2, "R1", "high time", hi, DIV/2);
  endtask

  task automatic test_hold_width();
    int t0;
    while (hold_n) @(negedge clk);
    t0 = ncyc;
    while (!hold_n) @(negedge clk);
    check(ncyc - t0 == DIV, "R3", "strobe width", ncyc - t0, DIV);
  endtask

  task automatic test_conversion();
    int t, t2;
    logic [7:0] id;
    wait_hold_rise(t);
    id = conv_id;
    for (int i = 0; i < 3; i++) begin
      while (!wr_en && !err) @(negedge clk);
      check(!err, "R4", "no error on normal conversion", err, 0);
      check(ncyc - t == (19 + i) * DIV, (i == 0) ? "R4" : "R6", "write time", ncyc - t, (19 + i) * DIV);
      check(wr_ch == 2'(i), "R5", "channel order", wr_ch, i);
      check(wr_data == {id, 5'b0, 3'(i)}, "R6", "captured word", wr_data, {id, 5'b0, 3'(i)});
      @(negedge clk);
      check(!wr_en, "R6", "single-cycle write", wr_en, 0);
    end
    wait_hold_rise(t2);
    check(t2 - t == 22 * DIV, "R7", "strobe spacing", t2 - t, 22 * DIV);
  endtask

  task automatic test_timeout();
    int t, nw;
    eoc_en = 0;
    wait_hold_rise(t);
    nw = 0;
    while (!err) begin
      if (wr_en) nw++;
      @(negedge clk);
    end
    check(ncyc - t == TIMEOUT * DIV, "R8", "timeout distance", ncyc - t, TIMEOUT * DIV);
    check(!hold_n, "R8", "strobe with error", hold_n, 0);
    check(nw == 0 && !wr_en, "R8", "no write on timeout", nw, 0);
    @(negedge clk);
    check(!err, "R8", "single-cycle error", err, 0);
    eoc_en = 1;
    test_conversion();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_sampclk();
    test_hold_width();
    test_conversion();
    test_conversion();
    test_timeout();
    test_hold_width();
    test_conversion();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (ncyc > 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", ncyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule